// File: doc/BRIEF.md
# Programmable Interval Timer with Single Compare

A 16-bit tick counter that measures time in units of an external tick strobe. Either of two tick strobes is picked by a control bit and passed through a power-of-two prescaler (1, 2, 4 or 8). The counter advances once on each divided tick. It has three running behaviours. When stopped it holds its value. In up mode it runs from zero to a compare value and then restarts at zero, so the period is compare+1 divided ticks. In continuous mode it runs from zero to 0xFFFF and wraps, and the compare value has no effect on the sequence.

Whenever the counter moves onto the compare value, a sticky match flag is set. The interrupt output is the flag gated by an enable bit. Software configures the timer through a small register write port. That port can also zero the counter and the prescaler, and it can clear the flag by writing a 1 to it. To get a periodic interrupt of period T, load the compare with T·f/div − 1 and use up mode. Continuous mode is meant for a free-running timebase whose match repeats every 65536 divided ticks.

Top module: `cmp_timer`

## Requirements
- R1: After synchronous reset, `count_o` is 0 and `irq_o` is 0. The mode is stop, the divider is ÷1, source A is selected, the interrupt enable is off and the compare value is 0.
- R2: Write address 0 is the control word. Its fields are bits [1:0] mode (00 stop, 01 up, 10 continuous, 11 treated as stop), [3:2] divider select, [4] source select, [5] interrupt enable, [6] counter clear and [7] flag clear. Write address 1 loads the compare value. In up mode, a divided tick moves the counter from the compare value back to 0, so the period is compare+1 divided ticks.
- R3: In continuous mode the counter runs up to 0xFFFF and then wraps to 0, whatever the compare value is. With a fixed compare value, the match recurs every 65536 divided ticks.
- R4: The divider select value d (0..3) divides the selected tick strobe by 2^d. The counter advances on the ticks numbered 2^d, 2·2^d, and so on, counted after a clear. Cycles without a tick do not count.
- R5: `irq_o` equals the match flag ANDed with the interrupt enable. Clearing the enable hides a pending flag without losing it.
- R6: Writing control with bit 7 set clears the match flag. Ticks that bring no match leave the flag clear.
- R7: The flag is set on the edge where a divided tick moves the counter onto the compare value. A flag clear in that same cycle does not prevent the set.
- R8: In stop mode, or with mode code 11, the counter and the prescaler hold their values while ticks arrive.
- R9: Writing control with bit 6 set zeroes the counter and the prescaler on that edge. This takes priority over a tick in the same cycle.
- R10: Source select 0 counts `tick_a_i` and source select 1 counts `tick_b_i`. The other strobe is ignored.
- R11: In up mode, a counter that is already above the compare value returns to 0 on the next divided tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_a_i | input | 1 | Tick strobe A, one cycle per tick |
| tick_b_i | input | 1 | Tick strobe B, one cycle per tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control word, 1: compare value |
| wr_data_i | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| irq_o | output | 1 | Match flag gated by the interrupt enable |

## Verification
A continuous tick stream in up mode with a small compare value checks the compare+1 restart period. It also pins down the exact edge on which the flag is set. Gapped tick streams at each divider ratio tell ÷2^d counting apart from cycle counting. Strobes driven on the unselected source show whether source selection really isolates the inputs. A full 65536-tick continuous run with a fixed compare value separates a wrap at 0xFFFF from a compare-based reload. Writes that coincide with ticks or matches (a clear during a tick, a flag clear during a match) test the priority rules.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_STOP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_CONT = 2'b10,
    MODE_RSVD = 2'b11
  } tmr_mode_e;

  // control word layout, MSB first
  typedef struct packed {
    logic      flag_clr;
    logic      cnt_clr;
    logic      irq_en;
    logic      src_sel;
    logic [1:0] div_sel;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output tmr_mode_e        mode_o,
  output logic [1:0]       div_o,
  output logic             src_o,
  output logic             ie_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             cnt_clr_o,
  output logic             flag_clr_o
);

  tmr_ctrl_t wr_ctrl;
  logic      ctrl_we;
  logic      cmp_we;

  assign wr_ctrl    = tmr_ctrl_t'(wr_data_i[CTRL_W-1:0]);
  assign ctrl_we    = wr_en_i && !wr_addr_i;
  assign cmp_we     = wr_en_i &&  wr_addr_i;
  assign cnt_clr_o  = ctrl_we && wr_ctrl.cnt_clr;
  assign flag_clr_o = ctrl_we && wr_ctrl.flag_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_STOP;
      div_o  <= '0;
      src_o  <= 1'b0;
      ie_o   <= 1'b0;
    end else if (ctrl_we) begin
      mode_o <= wr_ctrl.mode;
      div_o  <= wr_ctrl.div_sel;
      src_o  <= wr_ctrl.src_sel;
      ie_o   <= wr_ctrl.irq_en;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cmp_o <= '0;
    else if (cmp_we) cmp_o <= wr_data_i;
  end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             src_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             adv_o
);

  localparam int PRE_W = (1 << DIV_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   div_onehot;
  logic [PRE_W-1:0] mask;
  logic             tick_sel;

  assign tick_sel   = src_i ? tick_b_i : tick_a_i;
  assign div_onehot = (PRE_W+1)'(1) << div_i;
  assign mask       = PRE_W'(div_onehot - 1'b1);
  assign adv_o      = run_i && tick_sel && !clr_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr_i)          pre_q <= '0;
    else if (run_i && tick_sel) pre_q <= pre_q + 1'b1;
  end

  // R4
  div_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_o && div_i != '0) |=> (!adv_o || div_i == '0));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv_i,
  input  logic             clr_i,
  input  tmr_mode_e        mode_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);

  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (mode_i == MODE_UP && cnt_o >= cmp_i) cnt_nxt = '0;
    else                                     cnt_nxt = cnt_o + 1'b1;
  end

  assign match_o = adv_i && (cnt_nxt == cmp_i);

  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (adv_i)   cnt_o <= cnt_nxt;
  end

  // R2
  up_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && mode_i == MODE_UP && cnt_o == cmp_i) |=> (cnt_o == '0));

  // R3
  cont_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (adv_i && mode_i == MODE_CONT && (&cnt_o)) |=> (cnt_o == '0));

  // R8
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_i == MODE_STOP || mode_i == MODE_RSVD) && !clr_i) |=> $stable(cnt_o));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic irq_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_o = flag_q && ie_i;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_q);

  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_q);

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_a_i,
  input  logic             tick_b_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);

  tmr_mode_e        mode;
  logic [1:0]       div_sel;
  logic             src_sel;
  logic             irq_en;
  logic [CNT_W-1:0] cmp_val;
  logic             cnt_clr;
  logic             flag_clr;
  logic             run;
  logic             adv;
  logic             match;

  assign run = (mode == MODE_UP) || (mode == MODE_CONT);

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .mode_o     (mode),
    .div_o      (div_sel),
    .src_o      (src_sel),
    .ie_o       (irq_en),
    .cmp_o      (cmp_val),
    .cnt_clr_o  (cnt_clr),
    .flag_clr_o (flag_clr)
  );

  tmr_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .tick_a_i (tick_a_i),
    .tick_b_i (tick_b_i),
    .src_i    (src_sel),
    .run_i    (run),
    .clr_i    (cnt_clr),
    .div_i    (DIV_W'(div_sel)),
    .adv_o    (adv)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .adv_i   (adv),
    .clr_i   (cnt_clr),
    .mode_i  (mode),
    .cmp_i   (cmp_val),
    .cnt_o   (count_o),
    .match_o (match)
  );

  tmr_flag u_flag (
    .clk   (clk),
    .rst   (rst),
    .set_i (match),
    .clr_i (flag_clr),
    .ie_i  (irq_en),
    .irq_o (irq_o)
  );

  // R10
  idle_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clr && !(src_sel ? tick_b_i : tick_a_i)) |=> $stable(count_o));

endmodule

// File: tb/cmp_timer_tb.sv
`timescale 1ns/1ps
module cmp_timer_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_a = 1'b0, tick_b = 1'b0;
  logic        wr_en = 1'b0, wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] exp_cnt_q[$];
  logic        exp_irq_q[$];
  string       exp_tag_q[$];

  // bench model state
  logic [15:0] m_cnt, m_cmp;
  logic [2:0]  m_pre;
  logic [1:0]  m_mode, m_div;
  logic        m_src, m_ie, m_flag;

  always #2.5 clk = ~clk;

  cmp_timer u_dut (
    .clk(clk), .rst(rst), .tick_a_i(tick_a), .tick_b_i(tick_b),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .irq_o(irq)
  );

  task automatic step(input logic ta, input logic tb, input logic w,
                      input logic a, input logic [15:0] d, input string tag);
    logic clr, fclr, sel, adv, setf;
    logic [15:0] nxt;
    logic [2:0] mask;
    @(negedge clk);
    tick_a = ta; tick_b = tb; wr_en = w; wr_addr = a; wr_data = d;
    clr  = w && !a && d[6];
    fclr = w && !a && d[7];
    sel  = m_src ? tb : ta;
    adv  = 1'b0; setf = 1'b0;
    if (clr) begin
      m_cnt = '0; m_pre = '0;
    end else if ((m_mode == 2'b01 || m_mode == 2'b10) && sel) begin
      mask = 3'((1 << m_div) - 1);
      adv = ((m_pre & mask) == mask);
      m_pre = m_pre + 3'd1;
    end
    if (adv) begin
      nxt = (m_mode == 2'b01 && m_cnt >= m_cmp) ? 16'd0 : m_cnt + 16'd1;
      setf = (nxt == m_cmp);
      m_cnt = nxt;
    end
    m_flag = setf | (m_flag & !fclr);
    if (w && !a) begin
      m_mode = d[1:0]; m_div = d[3:2]; m_src = d[4]; m_ie = d[5];
    end
    if (w && a) m_cmp = d;
    exp_cnt_q.push_back(m_cnt);
    exp_irq_q.push_back(m_flag & m_ie);
    exp_tag_q.push_back(tag);
  endtask

  task automatic wr_ctrl(input logic [1:0] mode, input logic [1:0] dv, input logic src,
                         input logic ie, input logic cclr, input logic fclr,
                         input logic ta, input string tag);
    step(ta, 1'b0, 1'b1, 1'b0, {8'h00, fclr, cclr, ie, src, dv, mode}, tag);
  endtask

  task automatic wr_cmp(input logic [15:0] v, input string tag);
    step(1'b0, 1'b0, 1'b1, 1'b1, v, tag);
  endtask

  task automatic ticks(input int n, input logic ta, input logic tb, input string tag);
    for (int i = 0; i < n; i++) step(ta, tb, 1'b0, 1'b0, 16'h0, tag);
  endtask

  // monitor: compares each expected item one step after it was pushed
  always @(posedge clk) begin
    #1;
    if (exp_cnt_q.size() > 0) begin
      logic [15:0] ec; logic ei; string t;
      ec = exp_cnt_q.pop_front();
      ei = exp_irq_q.pop_front();
      t  = exp_tag_q.pop_front();
      total++;
      if (count !== ec || irq !== ei) begin
        bad++;
        $display("FAIL %s: count=%0d irq=%0b expected count=%0d irq=%0b",
                 t, count, irq, ec, ei);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_cnt = '0; m_cmp = '0; m_pre = '0; m_mode = '0; m_div = '0;
    m_src = 1'b0; m_ie = 1'b0; m_flag = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    ticks(2, 1'b0, 1'b0, "R1");
    // R1: ticks in the reset stop mode do not move the counter
    ticks(3, 1'b1, 1'b0, "R1");

    // R2 up mode, compare 4: period of 5 ticks
    wr_cmp(16'd4, "R2");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
    ticks(12, 1'b1, 1'b0, "R2");

    // R5 enable gating with pending flag
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
    ticks(2, 1'b0, 1'b0, "R5");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");

    // R6 flag clear, then non-matching ticks keep it low
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
    ticks(2, 1'b1, 1'b0, "R6");

    // R7 flag clear coinciding with the matching tick
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R7");
    ticks(3, 1'b1, 1'b0, "R7");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, "R7");
    ticks(2, 1'b0, 1'b0, "R7");

    // R4 divide by 4 and by 8, continuous and gapped ticks
    wr_ctrl(2'b01, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    ticks(22, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 12; i++) begin
      ticks(1, 1'b1, 1'b0, "R4");
      ticks(2, 1'b0, 1'b0, "R4");
    end
    wr_ctrl(2'b10, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    ticks(20, 1'b1, 1'b0, "R4");
    wr_ctrl(2'b10, 2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
    ticks(9, 1'b1, 1'b0, "R4");

    // R10 source B selected: strobe A ignored, strobe B counted
    wr_ctrl(2'b01, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R10");
    ticks(5, 1'b1, 1'b0, "R10");
    ticks(3, 1'b0, 1'b1, "R10");

    // R8 stop and reserved mode hold
    wr_ctrl(2'b00, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    ticks(4, 1'b1, 1'b1, "R8");
    wr_ctrl(2'b11, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    ticks(4, 1'b1, 1'b1, "R8");

    // R9 clear in stop mode and clear against a tick in up mode
    wr_ctrl(2'b00, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    wr_cmp(16'd50, "R9");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R9");
    ticks(6, 1'b1, 1'b0, "R9");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R9");
    ticks(2, 1'b1, 1'b0, "R9");

    // R11 up mode entered with count above compare
    wr_ctrl(2'b10, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R11");
    ticks(10, 1'b1, 1'b0, "R11");
    wr_cmp(16'd5, "R11");
    wr_ctrl(2'b01, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    ticks(3, 1'b1, 1'b0, "R11");

    // R3 continuous with compare 3: wrap at 0xFFFF, match every 65536 ticks
    wr_cmp(16'd3, "R3");
    wr_ctrl(2'b10, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    ticks(3, 1'b1, 1'b0, "R3");
    wr_ctrl(2'b10, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R3");
    ticks(65536, 1'b1, 1'b0, "R3");
    ticks(2, 1'b0, 1'b0, "R3");

    wait (exp_cnt_q.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule